// File: doc/BRIEF.md
# Compare output waveform unit

This unit drives one compare output pin of a timer from events that the counter supplies. The counter itself lives elsewhere; the unit receives a compare-match pulse, a BOTTOM pulse, the count direction, the active waveform mode and a flag saying whether TOP comes from compare register A. It keeps a one-bit output latch. On each event it toggles, clears, sets or holds that latch, according to a 2-bit output mode code. The same code means different actions in the non-PWM, fast PWM and phase-correct PWM modes.

Software can force a compare through a strobe, which acts like a real match but only in the non-PWM modes. The latch keeps its value across waveform mode changes, so firmware can preset the latch with a forced compare in normal mode and then switch to a PWM mode. The pin shows the latch only when the output mode code is connected and the pin direction bit marks the pin as an output. Otherwise the pin shows the general-purpose port value. A parameter selects whether the instance serves channel A, which alone may toggle in the PWM modes.

Top module: `cmp_out_unit`

## Requirements
- R1: After reset the latch is 0. With output mode code 00 the pin shows port_val_i.
- R2: Output mode code 00 disconnects the latch. The pin equals port_val_i whatever the latch and pin direction are.
- R3: Waveform mode encoding is 00 normal, 01 CTC, 10 fast PWM, 11 phase-correct PWM. In normal and CTC modes a match with code 01 toggles the latch, with code 10 clears it, and with code 11 sets it. The change shows on the pin from the clock edge that samples the match.
- R4: In fast PWM mode, code 10 clears the latch on a match and sets it on BOTTOM. Code 11 sets it on a match and clears it on BOTTOM.
- R5: In fast PWM mode, when a match and BOTTOM arrive in the same cycle, the BOTTOM action is the one that lands in the latch.
- R6: In phase-correct PWM mode, code 10 clears the latch on a match while counting up and sets it on a match while counting down. Code 11 does the reverse. BOTTOM alone leaves the latch unchanged.
- R7: In the PWM modes, code 01 toggles the latch on a match only on a channel A instance whose TOP comes from compare A. Otherwise the latch holds and the pin shows port_val_i, as for code 00.
- R8: A force strobe applies the non-PWM match action for the current code in normal and CTC modes. In PWM modes the strobe has no effect on the latch.
- R9: Without a match, BOTTOM or force event the latch holds its value, also when the waveform mode changes.
- R10: The pin shows the latch only when the code is connected and pin_dir_i is 1. With pin_dir_i at 0 the pin shows port_val_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wave_mode_i | input | 2 | Waveform mode: 00 normal, 01 CTC, 10 fast PWM, 11 phase-correct |
| top_from_a_i | input | 1 | TOP is taken from compare register A |
| out_mode_i | input | 2 | Compare output mode code |
| match_i | input | 1 | Compare match pulse from the counter |
| bottom_i | input | 1 | Counter at BOTTOM pulse |
| count_down_i | input | 1 | Counter is counting down |
| force_i | input | 1 | Forced compare strobe |
| pin_dir_i | input | 1 | Pin direction, 1 = output |
| port_val_i | input | 1 | General-purpose port value |
| pin_o | output | 1 | Pin value |

## Verification
The latch takes an event on the same rising edge that samples match_i, bottom_i or force_i. pin_o is combinational from the latch and the current code, direction and port value. So an event result is due one edge after the strobe, and a change of code, direction or port value shows in the same cycle. The bench drives inputs on the falling edge, lets exactly one rising edge pass, drops the strobes and compares pin_o on the next falling edge. Connection and direction checks are made with no event pending, so the latch cannot move between stimulus and sample.

// File: rtl/cmp_out_pkg.sv
package cmp_out_pkg;
  localparam int unsigned WAVE_W = 2;
  localparam int unsigned CODE_W = 2;

  typedef enum logic [WAVE_W-1:0] {
    WM_NORMAL = 2'b00,
    WM_CTC    = 2'b01,
    WM_FAST   = 2'b10,
    WM_PHASE  = 2'b11
  } wave_mode_e;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } latch_act_e;

  localparam logic [CODE_W-1:0] CODE_OFF = 2'b00;
  localparam logic [CODE_W-1:0] CODE_TOG = 2'b01;
  localparam logic [CODE_W-1:0] CODE_CLR = 2'b10;
  localparam logic [CODE_W-1:0] CODE_SET = 2'b11;
endpackage

// File: rtl/cmp_action_decode.sv
module cmp_action_decode
  import cmp_out_pkg::*;
#(
  parameter bit CHAN_IS_A = 1'b1
) (
  input  wave_mode_e        wave_mode_i,
  input  logic              top_from_a_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              match_i,
  input  logic              bottom_i,
  input  logic              count_down_i,
  input  logic              force_i,
  output latch_act_e        act_o,
  output logic              connected_o
);
  logic toggle_ok;
  logic is_pwm;

  generate
    if (CHAN_IS_A) begin : g_chan_a
      assign toggle_ok = top_from_a_i;
    end else begin : g_chan_other
      assign toggle_ok = 1'b0;
    end
  endgenerate

  assign is_pwm = (wave_mode_i == WM_FAST) || (wave_mode_i == WM_PHASE);

  always_comb begin
    act_o = ACT_HOLD;
    unique case (wave_mode_i)
      WM_NORMAL, WM_CTC: begin
        if (match_i || force_i) begin
          unique case (code_i)
            CODE_TOG: act_o = ACT_TOGGLE;
            CODE_CLR: act_o = ACT_CLEAR;
            CODE_SET: act_o = ACT_SET;
            default:  act_o = ACT_HOLD;
          endcase
        end
      end
      WM_FAST: begin
        if (match_i) begin
          unique case (code_i)
            CODE_TOG: act_o = toggle_ok ? ACT_TOGGLE : ACT_HOLD;
            CODE_CLR: act_o = ACT_CLEAR;
            CODE_SET: act_o = ACT_SET;
            default:  act_o = ACT_HOLD;
          endcase
        end
        // BOTTOM evaluated last so it overrides a same-cycle match
        if (bottom_i) begin
          if (code_i == CODE_CLR) act_o = ACT_SET;
          else if (code_i == CODE_SET) act_o = ACT_CLEAR;
        end
      end
      WM_PHASE: begin
        if (match_i) begin
          unique case (code_i)
            CODE_TOG: act_o = toggle_ok ? ACT_TOGGLE : ACT_HOLD;
            CODE_CLR: act_o = count_down_i ? ACT_SET : ACT_CLEAR;
            CODE_SET: act_o = count_down_i ? ACT_CLEAR : ACT_SET;
            default:  act_o = ACT_HOLD;
          endcase
        end
      end
      default: act_o = ACT_HOLD;
    endcase
  end

  assign connected_o = (code_i != CODE_OFF) &&
                       !(is_pwm && (code_i == CODE_TOG) && !toggle_ok);
endmodule

// File: rtl/cmp_out_latch.sv
module cmp_out_latch
  import cmp_out_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  latch_act_e act_i,
  output logic       latch_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_o <= 1'b0;
    end else begin
      unique case (act_i)
        ACT_TOGGLE: latch_o <= ~latch_o;
        ACT_CLEAR:  latch_o <= 1'b0;
        ACT_SET:    latch_o <= 1'b1;
        default:    latch_o <= latch_o;
      endcase
    end
  end

  p_toggle_flips_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == ACT_TOGGLE) |=> (latch_o != $past(latch_o)));
endmodule

// File: rtl/cmp_pin_mux.sv
module cmp_pin_mux (
  input  logic connected_i,
  input  logic pin_dir_i,
  input  logic latch_i,
  input  logic port_val_i,
  output logic pin_o
);
  assign pin_o = (connected_i && pin_dir_i) ? latch_i : port_val_i;
endmodule

// File: rtl/cmp_out_unit.sv
module cmp_out_unit
  import cmp_out_pkg::*;
#(
  parameter bit CHAN_IS_A = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WAVE_W-1:0] wave_mode_i,
  input  logic              top_from_a_i,
  input  logic [CODE_W-1:0] out_mode_i,
  input  logic              match_i,
  input  logic              bottom_i,
  input  logic              count_down_i,
  input  logic              force_i,
  input  logic              pin_dir_i,
  input  logic              port_val_i,
  output logic              pin_o
);
  latch_act_e act;
  logic       connected;
  logic       latch_q;
  wave_mode_e wave;

  assign wave = wave_mode_e'(wave_mode_i);

  cmp_action_decode #(.CHAN_IS_A(CHAN_IS_A)) u_decode (
    .wave_mode_i  (wave),
    .top_from_a_i (top_from_a_i),
    .code_i       (out_mode_i),
    .match_i      (match_i),
    .bottom_i     (bottom_i),
    .count_down_i (count_down_i),
    .force_i      (force_i),
    .act_o        (act),
    .connected_o  (connected)
  );

  cmp_out_latch u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .act_i   (act),
    .latch_o (latch_q)
  );

  cmp_pin_mux u_mux (
    .connected_i (connected),
    .pin_dir_i   (pin_dir_i),
    .latch_i     (latch_q),
    .port_val_i  (port_val_i),
    .pin_o       (pin_o)
  );

  p_nonpwm_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wave_mode_i[1] && match_i && out_mode_i == CODE_CLR) |=> !latch_q);
  p_nonpwm_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wave_mode_i[1] && match_i && out_mode_i == CODE_SET) |=> latch_q);
  p_fast_bottom_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wave_mode_i == 2'b10 && bottom_i && out_mode_i == CODE_CLR) |=> latch_q);
  p_fast_bottom_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wave_mode_i == 2'b10 && bottom_i && match_i && out_mode_i == CODE_SET)
    |=> !latch_q);
  p_phase_down_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wave_mode_i == 2'b11 && match_i && count_down_i && out_mode_i == CODE_CLR)
    |=> latch_q);
  p_force_ignored_pwm_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wave_mode_i[1] && force_i && !match_i && !bottom_i) |=> $stable(latch_q));
  p_hold_no_event_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!match_i && !bottom_i && !force_i) |=> $stable(latch_q));
  p_disconnected_port_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_mode_i == CODE_OFF) |-> (pin_o == port_val_i));
endmodule

// File: tb/cmp_out_unit_bench.sv
module cmp_out_unit_bench;
  logic       clk;
  logic       rst_n;
  logic [1:0] wave;
  logic       top_a;
  logic [1:0] code;
  logic       match;
  logic       bottom;
  logic       down;
  logic       frc;
  logic       dir;
  logic       port;
  logic       pin_a;
  logic       pin_b;
  int         n_chk;
  int         n_bad;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  cmp_out_unit #(.CHAN_IS_A(1'b1)) u_cmp_out_unit (
    .clk_i(clk), .rst_ni(rst_n), .wave_mode_i(wave), .top_from_a_i(top_a),
    .out_mode_i(code), .match_i(match), .bottom_i(bottom),
    .count_down_i(down), .force_i(frc), .pin_dir_i(dir),
    .port_val_i(port), .pin_o(pin_a)
  );

  cmp_out_unit #(.CHAN_IS_A(1'b0)) u_cmp_out_unit_b (
    .clk_i(clk), .rst_ni(rst_n), .wave_mode_i(wave), .top_from_a_i(top_a),
    .out_mode_i(code), .match_i(match), .bottom_i(bottom),
    .count_down_i(down), .force_i(frc), .pin_dir_i(dir),
    .port_val_i(port), .pin_o(pin_b)
  );

  task automatic check(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // one-cycle event pulse; sampled on the falling edge after the capturing edge
  task automatic pulse(input logic m, input logic b, input logic f);
    match = m; bottom = b; frc = f;
    step();
    match = 1'b0; bottom = 1'b0; frc = 1'b0;
  endtask

  task automatic t_reset();
    code = 2'b00; dir = 1'b1; port = 1'b1;
    #1 check(pin_a, 1'b1, "R1 port shown after reset");
    port = 1'b0;
    #1 check(pin_a, 1'b0, "R2 code 00 follows port");
    code = 2'b11; port = 1'b1;
    #1 check(pin_a, 1'b0, "R1 latch zero after reset");
  endtask

  task automatic t_nonpwm();
    wave = 2'b00; port = 1'b0; code = 2'b11;
    pulse(1, 0, 0); check(pin_a, 1'b1, "R3 normal set");
    code = 2'b10;
    pulse(1, 0, 0); check(pin_a, 1'b0, "R3 normal clear");
    wave = 2'b01; code = 2'b01;
    pulse(1, 0, 0); check(pin_a, 1'b1, "R3 ctc toggle 1");
    pulse(1, 0, 0); check(pin_a, 1'b0, "R3 ctc toggle 2");
  endtask

  task automatic t_force();
    wave = 2'b00; code = 2'b11; port = 1'b0;
    pulse(0, 0, 1); check(pin_a, 1'b1, "R8 force set in normal");
    wave = 2'b10; code = 2'b10;
    pulse(0, 0, 1); check(pin_a, 1'b1, "R8 force ignored fast");
    wave = 2'b11;
    pulse(0, 0, 1); check(pin_a, 1'b1, "R8 force ignored phase");
  endtask

  task automatic t_fast();
    wave = 2'b10; code = 2'b10; port = 1'b0;
    pulse(1, 0, 0); check(pin_a, 1'b0, "R4 fast 10 clear on match");
    pulse(0, 1, 0); check(pin_a, 1'b1, "R4 fast 10 set at bottom");
    code = 2'b11;
    pulse(0, 1, 0); check(pin_a, 1'b0, "R4 fast 11 clear at bottom");
    pulse(1, 0, 0); check(pin_a, 1'b1, "R4 fast 11 set on match");
    pulse(1, 1, 0); check(pin_a, 1'b0, "R5 fast 11 bottom wins");
    code = 2'b10;
    pulse(1, 1, 0); check(pin_a, 1'b1, "R5 fast 10 bottom wins");
  endtask

  task automatic t_phase();
    wave = 2'b11; code = 2'b10; port = 1'b0;
    down = 1'b0; pulse(1, 0, 0); check(pin_a, 1'b0, "R6 phase 10 up clear");
    down = 1'b1; pulse(1, 0, 0); check(pin_a, 1'b1, "R6 phase 10 down set");
    code = 2'b11;
    down = 1'b1; pulse(1, 0, 0); check(pin_a, 1'b0, "R6 phase 11 down clear");
    down = 1'b0; pulse(1, 0, 0); check(pin_a, 1'b1, "R6 phase 11 up set");
    code = 2'b10;
    pulse(0, 1, 0); check(pin_a, 1'b1, "R6 phase bottom ignored");
  endtask

  task automatic t_toggle_pwm();
    // both latches are 1 here; resync B with a set in normal mode
    wave = 2'b00; code = 2'b11; port = 1'b0;
    pulse(1, 0, 0);
    check(pin_b, 1'b1, "R3 chan B set");
    wave = 2'b10; top_a = 1'b1; code = 2'b01;
    pulse(1, 0, 0);
    check(pin_a, 1'b0, "R7 chan A toggles in fast");
    port = 1'b1;
    #1 check(pin_b, 1'b1, "R7 chan B shows port");
    port = 1'b0;
    #1 check(pin_b, 1'b0, "R7 chan B shows port low");
    top_a = 1'b0; port = 1'b1;
    pulse(1, 0, 0);
    check(pin_a, 1'b1, "R7 chan A no toggle without top A");
    code = 2'b11;
    #1 check(pin_a, 1'b0, "R7 chan A latch held");
    check(pin_b, 1'b1, "R7 chan B latch held");
  endtask

  task automatic t_hold();
    code = 2'b11; port = 1'b1;
    wave = 2'b00; step(); check(pin_a, 1'b0, "R9 hold normal");
    wave = 2'b10; step(); check(pin_a, 1'b0, "R9 hold fast");
    wave = 2'b11; step(); check(pin_a, 1'b0, "R9 hold phase");
    wave = 2'b00; pulse(0, 0, 1);
    wave = 2'b10; step(); check(pin_a, 1'b1, "R9 preset kept into fast");
    wave = 2'b11; step(); check(pin_a, 1'b1, "R9 preset kept into phase");
  endtask

  task automatic t_dir();
    code = 2'b11; port = 1'b0; dir = 1'b0;
    #1 check(pin_a, 1'b0, "R10 dir 0 shows port");
    dir = 1'b1;
    #1 check(pin_a, 1'b1, "R10 dir 1 shows latch");
    code = 2'b00;
    #1 check(pin_a, 1'b0, "R2 code 00 overrides dir");
    code = 2'b11; dir = 1'b0; port = 1'b1;
    #1 check(pin_a, 1'b1, "R10 dir 0 port high");
    step();
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; wave = 2'b00; top_a = 1'b0; code = 2'b00;
    match = 1'b0; bottom = 1'b0; down = 1'b0; frc = 1'b0;
    dir = 1'b0; port = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_nonpwm();
    t_force();
    t_fast();
    t_phase();
    t_toggle_pwm();
    t_hold();
    t_dir();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule